// File: doc/BRIEF.md
# Serial Bus Device-Selection Layer

This block is the addressing layer of a slave on a single-wire, open-drain serial bus. It sits between a bit-level front end and a memory-function layer. The front end handles the analog timing. It reports each bus reset pulse and whether that pulse was long. It reports each bit the master wrote. It also asks for a bit whenever the master opens a read slot. After each reset the layer collects an 8-bit command, least significant bit first. It then runs one of seven addressing sequences against a 64-bit registration code. When a sequence succeeds, the device is handed on to the memory-function layer.

The seven sequences are:
- Read the code out.
- Compare the master's 64 bits against the code.
- Skip the exchange entirely.
- Take part in a bitwise binary search, optionally only when an alarm qualifier is raised.
- Two variants that also switch the bus to high-speed mode.

The high-speed flag is sticky. Only a long reset clears it. A separate output reports whether the top byte of the code is a valid CRC-8 of the lower 56 bits.

Top module: `owrom_layer`

## Requirements
- R1: After `rst_n` low, `selected_o`=0, `overdrive_o`=0 and `tx_bit_o`=1. Written bits are ignored until the first bus reset pulse.
- R2: After each bus reset the command byte is taken from 8 written bits, least significant bit first. `selected_o` stays 0 before the 8th bit. Any code other than 33h, 55h, F0h, ECh, CCh, 3Ch or 69h leaves the device unselected. All later slots are then ignored (read slots return 1) until the next reset.
- R3: Command CCh sets `selected_o`=1 from the cycle after the 8th command bit.
- R4: Command 33h returns the code on the next 64 read slots, bit 0 first. After the 64th slot `selected_o`=1.
- R5: Command 55h compares the next 64 written bits with code bits 0..63. If all are equal, `selected_o`=1. On the first unequal bit the device drops and stays unselected until the next reset.
- R6: Command F0h runs 64 triplets. Read slot 1 returns code bit i, read slot 2 returns its complement, then a written bit gives the master's direction. After 64 matching directions `selected_o`=1.
- R7: In a search, a written direction unequal to code bit i drops the device. Every later read slot then returns 1 and `selected_o` stays 0 until the next reset.
- R8: Command ECh behaves as F0h if `cond_hit_i`=1 in the cycle the 8th command bit arrives. Otherwise it behaves as an unknown command.
- R9: Commands 3Ch and 69h set `overdrive_o`=1 from the cycle after the 8th command bit. 3Ch then selects like CCh, and 69h then compares like 55h.
- R10: `overdrive_o` is cleared only by a reset pulse with `bus_rst_long_i`=1, taking effect in the next cycle. Short resets leave it unchanged.
- R11: A reset pulse outranks any written bit or read request in the same cycle. That bit or request is discarded, and `selected_o`=0 in the next cycle. A long reset arriving together with the last bit of 3Ch or 69h leaves `overdrive_o`=0.
- R12: `code_crc_ok_o`=1 exactly when code bits 63:56 equal the CRC-8 of bits 55:0. The CRC uses polynomial x^8+x^5+x^4+1 with init 0, shifted bit 0 first in reflected form (feedback constant 8Ch).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst_i | input | 1 | One-cycle pulse: bus reset seen |
| bus_rst_long_i | input | 1 | Qualifies `bus_rst_i`: reset was long |
| rx_valid_i | input | 1 | One-cycle pulse: master wrote a bit |
| rx_bit_i | input | 1 | Value of the written bit |
| tx_req_i | input | 1 | One-cycle pulse: master read slot consumes `tx_bit_o` |
| tx_bit_o | output | 1 | Bit offered for the current read slot (1 = released) |
| reg_code_i | input | 64 | Registration code |
| cond_hit_i | input | 1 | Alarm qualifier for conditional search |
| selected_o | output | 1 | Device handed to memory-function layer |
| overdrive_o | output | 1 | High-speed mode flag |
| code_crc_ok_o | output | 1 | Code CRC byte is consistent |

## Verification
Two events can fall in the same cycle. One is a bus reset pulse. The other is the completion of a command byte, or a data bit mid-sequence. The bench drives a long reset in the very cycle that carries the 8th bit of the overdrive-skip command. It expects `overdrive_o` and `selected_o` both at 0 afterwards, and a fresh skip command to then select normally. A second case drives a reset together with a read request in the middle of a code read-out. It expects the request to be dropped and command reception to restart.

// File: rtl/owrom_pkg.sv
// Shared constants and state types for the device-selection layer.
// Assumes commands arrive least significant bit first, 8 bits wide.
package owrom_pkg;

    localparam int CMD_W = 8;
    localparam int CRC_W = 8;

    localparam logic [CMD_W-1:0] CMD_READ     = 8'h33;
    localparam logic [CMD_W-1:0] CMD_MATCH    = 8'h55;
    localparam logic [CMD_W-1:0] CMD_SEARCH   = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_CSEARCH  = 8'hEC;
    localparam logic [CMD_W-1:0] CMD_SKIP     = 8'hCC;
    localparam logic [CMD_W-1:0] CMD_OD_SKIP  = 8'h3C;
    localparam logic [CMD_W-1:0] CMD_OD_MATCH = 8'h69;

    // Reflected feedback constant of x^8 + x^5 + x^4 + 1
    localparam logic [CRC_W-1:0] CRC_POLY_REV = 8'h8C;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH,
        ST_SEL
    } sel_state_t;

    typedef enum logic [1:0] {
        PH_BIT,
        PH_CMP,
        PH_DIR
    } srch_phase_t;

endpackage

// File: rtl/owrom_crc8.sv
// Combinational CRC-8 of a data word, shifted bit 0 first, init 0.
// Assumes the data width is small enough to unroll (56 by default).
module owrom_crc8 #(
    parameter int DATA_W = 56
) (
    input  logic [DATA_W-1:0]             data_i,
    output logic [owrom_pkg::CRC_W-1:0]   crc_o
);
    import owrom_pkg::*;

    function automatic logic [CRC_W-1:0] crc_calc(input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic             fb;
        c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_REV;
        end
        return c;
    endfunction

    // Purpose: compute the CRC of the whole input word.
    always_comb begin
        crc_o = crc_calc(data_i);
    end

endmodule

// File: rtl/owrom_od_flag.sv
// Sticky high-speed mode flag: set by a command decode, cleared only
// by a long bus reset. Clear wins when both arrive together.
module owrom_od_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic od_o
);

    // Purpose: hold the mode flag between long resets.
    always_ff @(posedge clk) begin
        if (!rst_n)     od_o <= 1'b0;
        else if (clr_i) od_o <= 1'b0;
        else if (set_i) od_o <= 1'b1;
    end

    AST_OD_LONG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !od_o); // R10
    AST_OD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(od_o) |-> $past(clr_i)); // R10

endmodule

// File: rtl/owrom_ctrl.sv
// Command decoder and addressing sequencer. It consumes one-cycle bit
// events from the bus front end and walks the code for read, match and
// search. Assumes at most one of rx_valid_i / tx_req_i per cycle.
// A bus reset outranks both.
module owrom_ctrl #(
    parameter int CODE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_i,
    input  logic              rx_valid_i,
    input  logic              rx_bit_i,
    input  logic              tx_req_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              cond_i,
    output logic              tx_bit_o,
    output logic              selected_o,
    output logic              od_set_o
);
    import owrom_pkg::*;

    localparam int              IDX_W     = $clog2(CODE_W);
    localparam logic [IDX_W-1:0] CODE_LAST = IDX_W'(CODE_W - 1);
    localparam logic [IDX_W-1:0] CMD_LAST  = IDX_W'(CMD_W - 1);

    sel_state_t       st;
    srch_phase_t      ph;
    logic [IDX_W-1:0] cnt;
    logic [CMD_W-1:0] cmd_sr;
    logic [CMD_W-1:0] cmd_next;
    logic             cur_bit;
    logic             cmd_done;

    // Purpose: form the byte including the bit arriving now.
    always_comb begin
        cmd_next = {rx_bit_i, cmd_sr[CMD_W-1:1]};
        cur_bit  = code_i[cnt];
        cmd_done = (st == ST_CMD) && rx_valid_i && !bus_rst_i && (cnt == CMD_LAST);
    end

    // Purpose: sequence the command byte and the per-command bit walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            ph     <= PH_BIT;
            cnt    <= '0;
            cmd_sr <= '0;
        end else if (bus_rst_i) begin
            st  <= ST_CMD;
            ph  <= PH_BIT;
            cnt <= '0;
        end else begin
            case (st)
                ST_CMD: if (rx_valid_i) begin
                    cmd_sr <= cmd_next;
                    if (cnt == CMD_LAST) begin
                        cnt <= '0;
                        ph  <= PH_BIT;
                        case (cmd_next)
                            CMD_READ:                st <= ST_READ;
                            CMD_MATCH, CMD_OD_MATCH: st <= ST_MATCH;
                            CMD_SEARCH:              st <= ST_SRCH;
                            CMD_CSEARCH:             st <= cond_i ? ST_SRCH : ST_IDLE;
                            CMD_SKIP, CMD_OD_SKIP:   st <= ST_SEL;
                            default:                 st <= ST_IDLE;
                        endcase
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_READ: if (tx_req_i) begin
                    if (cnt == CODE_LAST) st <= ST_SEL;
                    else                  cnt <= cnt + 1'b1;
                end
                ST_MATCH: if (rx_valid_i) begin
                    if (rx_bit_i != cur_bit) st  <= ST_IDLE;
                    else if (cnt == CODE_LAST) st <= ST_SEL;
                    else                     cnt <= cnt + 1'b1;
                end
                ST_SRCH: begin
                    case (ph)
                        PH_BIT: if (tx_req_i) ph <= PH_CMP;
                        PH_CMP: if (tx_req_i) ph <= PH_DIR;
                        default: if (rx_valid_i) begin
                            if (rx_bit_i != cur_bit) st <= ST_IDLE;
                            else if (cnt == CODE_LAST) st <= ST_SEL;
                            else begin
                                cnt <= cnt + 1'b1;
                                ph  <= PH_BIT;
                            end
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Purpose: offer the bit for a read slot; released (1) otherwise.
    always_comb begin
        tx_bit_o = 1'b1;
        if (st == ST_READ) tx_bit_o = cur_bit;
        else if (st == ST_SRCH && ph == PH_BIT) tx_bit_o = cur_bit;
        else if (st == ST_SRCH && ph == PH_CMP) tx_bit_o = ~cur_bit;
    end

    // Purpose: export selection and the high-speed set strobe.
    always_comb begin
        selected_o = (st == ST_SEL);
        od_set_o   = cmd_done && ((cmd_next == CMD_OD_SKIP) || (cmd_next == CMD_OD_MATCH));
    end

    AST_RST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_i |=> !selected_o); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !bus_rst_i) |=> (st == ST_IDLE)); // R2
    AST_SRCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SRCH && ph == PH_DIR && rx_valid_i && !bus_rst_i && rx_bit_i != code_i[cnt])
        |=> (st == ST_IDLE)); // R7
    AST_MATCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MATCH && rx_valid_i && !bus_rst_i && rx_bit_i != code_i[cnt])
        |=> (st == ST_IDLE)); // R5
    AST_SEL_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CMD && !rx_valid_i && !bus_rst_i) |=> !selected_o); // R2

endmodule

// File: rtl/owrom_layer.sv
// Top of the device-selection layer: command sequencer, sticky mode
// flag and code CRC checker. Assumes bus events are one-cycle pulses
// from a bit-level front end running on the same clock.
module owrom_layer #(
    parameter int CODE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_i,
    input  logic              bus_rst_long_i,
    input  logic              rx_valid_i,
    input  logic              rx_bit_i,
    input  logic              tx_req_i,
    output logic              tx_bit_o,
    input  logic [CODE_W-1:0] reg_code_i,
    input  logic              cond_hit_i,
    output logic              selected_o,
    output logic              overdrive_o,
    output logic              code_crc_ok_o
);
    import owrom_pkg::*;

    localparam int DATA_W = CODE_W - CRC_W;

    logic             od_set;
    logic             od_clr;
    logic [CRC_W-1:0] crc_calc;

    owrom_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst_i  (bus_rst_i),
        .rx_valid_i (rx_valid_i),
        .rx_bit_i   (rx_bit_i),
        .tx_req_i   (tx_req_i),
        .code_i     (reg_code_i),
        .cond_i     (cond_hit_i),
        .tx_bit_o   (tx_bit_o),
        .selected_o (selected_o),
        .od_set_o   (od_set)
    );

    // Purpose: only a long reset may clear the mode flag.
    always_comb begin
        od_clr = bus_rst_i && bus_rst_long_i;
    end

    owrom_od_flag u_od (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (od_set),
        .clr_i (od_clr),
        .od_o  (overdrive_o)
    );

    owrom_crc8 #(.DATA_W(DATA_W)) u_crc (
        .data_i (reg_code_i[DATA_W-1:0]),
        .crc_o  (crc_calc)
    );

    // Purpose: compare the stored CRC byte with the computed one.
    always_comb begin
        code_crc_ok_o = (crc_calc == reg_code_i[CODE_W-1:DATA_W]);
    end

endmodule

// File: tb/sim_owrom_layer.sv
module sim_owrom_layer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        bus_long = 1'b0;
    logic        rx_v = 1'b0;
    logic        rx_b = 1'b0;
    logic        tx_req = 1'b0;
    logic        tx_bit;
    logic [63:0] code = 64'h0;
    logic        cond = 1'b0;
    logic        sel;
    logic        od;
    logic        crc_ok;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    owrom_layer u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_rst_i      (bus_rst),
        .bus_rst_long_i (bus_long),
        .rx_valid_i     (rx_v),
        .rx_bit_i       (rx_b),
        .tx_req_i       (tx_req),
        .tx_bit_o       (tx_bit),
        .reg_code_i     (code),
        .cond_hit_i     (cond),
        .selected_o     (sel),
        .overdrive_o    (od),
        .code_crc_ok_o  (crc_ok)
    );

    function automatic logic [7:0] ref_crc(input logic [55:0] d);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < 56; i++) begin
            logic m;
            m = r[0] ^ d[i];
            r = {1'b0, r[7:1]};
            r[7] = r[7] ^ m;
            r[3] = r[3] ^ m;
            r[2] = r[2] ^ m;
        end
        return r;
    endfunction

    function automatic logic [63:0] rand_code();
        return {$urandom(), $urandom()};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic l, input logic v, input logic b, input logic t);
        @(negedge clk);
        bus_rst = r; bus_long = l; rx_v = v; rx_b = b; tx_req = t;
        @(negedge clk);
        bus_rst = 0; bus_long = 0; rx_v = 0; tx_req = 0;
    endtask

    task automatic send_bit(input logic b);
        drive(0, 0, 1, b, 0);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic read_slot(output logic b);
        @(negedge clk);
        b = tx_bit;
        tx_req = 1;
        @(negedge clk);
        tx_req = 0;
    endtask

    task automatic bus_reset(input logic long_rst);
        drive(1, long_rst, 0, 0, 0);
    endtask

    // Full search; flip_pos >= 64 means no drop-out.
    task automatic run_search(input int flip_pos, input string req);
        logic a, c;
        bit dropped = 0;
        int err = 0;
        for (int i = 0; i < 64; i++) begin
            logic dir;
            read_slot(a);
            read_slot(c);
            if (dropped) begin
                if (a !== 1'b1 || c !== 1'b1) err++;
            end else begin
                if (a !== code[i] || c !== ~code[i]) err++;
            end
            dir = code[i] ^ (i == flip_pos);
            send_bit(dir);
            if (i == flip_pos) dropped = 1;
        end
        chk({req, " triplet bits"}, err, 0);
        chk({req, " selected after search"}, sel, (flip_pos >= 64) ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic b;
        void'($urandom(32'd1921));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 selected", sel, 0);
        chk("R1 overdrive", od, 0);
        chk("R1 tx released", tx_bit, 1);
        send_byte(8'hCC);
        chk("R1 bits ignored before bus reset", sel, 0);

        // R12 CRC directed and random
        code = 64'hA200_0000_01B8_1C02;
        @(negedge clk);
        chk("R12 known-good code", crc_ok, 1);
        code[60] = ~code[60];
        @(negedge clk);
        chk("R12 corrupted crc byte", crc_ok, 0);
        for (int k = 0; k < 8; k++) begin
            logic [63:0] cc;
            cc = rand_code();
            code = {ref_crc(cc[55:0]), cc[55:0]};
            @(negedge clk);
            chk("R12 random valid", crc_ok, 1);
            code[k*5] = ~code[k*5];
            @(negedge clk);
            chk("R12 random data flip", crc_ok, 0);
        end

        // R2 / R3 skip
        code = rand_code();
        bus_reset(0);
        for (int i = 0; i < 7; i++) send_bit(8'hCC >> i);
        chk("R2 not selected before 8th bit", sel, 0);
        send_bit(1'b1);
        chk("R3 skip selects", sel, 1);

        // R2 unknown command
        bus_reset(0);
        send_byte(8'hA5);
        read_slot(b);
        chk("R2 unknown: read slot released", b, 1);
        send_byte(8'hCC);
        chk("R2 unknown: later bits ignored", sel, 0);

        // R4 read
        bus_reset(0);
        send_byte(8'h33);
        begin
            logic [63:0] got;
            for (int i = 0; i < 64; i++) begin
                read_slot(b);
                got[i] = b;
            end
            chk("R4 read-out code", got, code);
        end
        chk("R4 selected after read", sel, 1);

        // R5 match pass and fail
        bus_reset(0);
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) send_bit(code[i]);
        chk("R5 match selects", sel, 1);
        bus_reset(0);
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) send_bit(code[i] ^ (i == 63));
        chk("R5 last-bit mismatch", sel, 0);
        send_byte(8'hCC);
        chk("R5 stays dropped", sel, 0);

        // R6 / R7 search directed
        bus_reset(0);
        send_byte(8'hF0);
        run_search(64, "R6");
        bus_reset(0);
        send_byte(8'hF0);
        run_search(0, "R7");

        // R8 conditional search
        cond = 0;
        bus_reset(0);
        send_byte(8'hEC);
        read_slot(b);
        chk("R8 no alarm: read slot released", b, 1);
        chk("R8 no alarm: unselected", sel, 0);
        cond = 1;
        bus_reset(0);
        send_byte(8'hEC);
        run_search(64, "R8");
        cond = 0;

        // R9 / R10 overdrive
        bus_reset(1);
        send_byte(8'h3C);
        chk("R9 od skip sets flag", od, 1);
        chk("R9 od skip selects", sel, 1);
        bus_reset(0);
        chk("R10 short reset keeps flag", od, 1);
        bus_reset(1);
        chk("R10 long reset clears flag", od, 0);
        send_byte(8'h69);
        chk("R9 od match sets flag", od, 1);
        for (int i = 0; i < 64; i++) send_bit(code[i]);
        chk("R9 od match selects", sel, 1);
        bus_reset(1);

        // R11 reset coincides with last command bit
        for (int i = 0; i < 7; i++) send_bit(8'h3C >> i);
        drive(1, 1, 1, 1'b0, 0);
        chk("R11 long reset wins: od", od, 0);
        chk("R11 long reset wins: sel", sel, 0);
        send_byte(8'hCC);
        chk("R11 command restarted", sel, 1);
        // R11 reset with read request mid read-out
        bus_reset(0);
        send_byte(8'h33);
        for (int i = 0; i < 5; i++) read_slot(b);
        drive(1, 0, 0, 0, 1);
        send_byte(8'h33);
        read_slot(b);
        chk("R11 read restarts at bit 0", b, code[0]);

        // Random mix
        for (int k = 0; k < 40; k++) begin
            int kind;
            code = rand_code();
            kind = $urandom_range(0, 2);
            bus_reset($urandom_range(0, 1));
            if (kind == 0) begin
                int p;
                p = $urandom_range(0, 80);
                send_byte(8'hF0);
                run_search(p, "R7 random search");
            end else if (kind == 1) begin
                int p;
                p = $urandom_range(0, 80);
                send_byte(8'h55);
                for (int i = 0; i < 64; i++) send_bit(code[i] ^ (i == p));
                chk("R5 random match", sel, (p >= 64) ? 1 : 0);
            end else begin
                logic [63:0] got;
                send_byte(8'h33);
                for (int i = 0; i < 64; i++) begin
                    read_slot(b);
                    got[i] = b;
                end
                chk("R4 random read", got, code);
            end
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule